// File: doc/BRIEF.md
# Scratchpad Cache-Way Memory

This block is a local memory that plugs into the slot of one way of a set-associative cache and answers with that way's timing. In the first cycle of a lookup the core presents an index. In the next cycle it presents the physical tag. In that same second cycle the block returns a hit flag and the read word. There is no tag array. A lookup hits when the physical address, formed by placing the tag above the index, lies inside a fixed window. The window's base and size are parameters. The index is 20 bits wide by default, so the window may cover up to 1 MB, where a normal cache way covers 4 KB.

Stores use the same two-cycle access. When a store hits, the enabled bytes are written at the end of the tag cycle. For that store the block raises a flag that stops the write-through to main memory. A second output stays high at all times, so the replacement logic never picks this way as a victim. The way therefore never receives refill data. A load to the same word that starts in the store's tag cycle reads the new bytes.

Top module: `spram_way`

## Requirements
- R1: `hit` is high in the cycle after `acc_en` was sampled high if, and only if, the address {`tag`, index registered from `acc_idx`} is at least `BASE` and below `BASE + SIZE_BYTES`. In every other cycle `hit` is low.
- R2: When `hit` is high, `rdata` carries the 32-bit word stored at word offset (address − `BASE`)/4 within the window.
- R3: A store (`st_en` high in a cycle where `hit` is high) writes byte lane i (`st_data[8i+7:8i]`) only where `st_be[i]` is 1. The other lanes of the word keep their values.
- R4: A store whose cycle has `hit` low changes no word in the array. This includes an address that shares the index bits of an in-window word but carries another tag.
- R5: A load whose index is presented in the tag cycle of a hitting store to the same word returns the merged new data in its own tag cycle.
- R6: `no_wthru` is high exactly in the cycles where `st_en` and `hit` are both high.
- R7: `no_replace` is 1 in every cycle, so this way is never chosen for replacement or refill.
- R8: While `rst_n` is low and in the first cycle after its release, `hit`, `no_wthru` and `rdata` are all 0.
- R9: When `hit` is low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Starts a lookup this cycle (index cycle) |
| acc_idx | input | IDX_W | Byte index of the lookup |
| tag | input | PA_W-IDX_W | Physical tag of the lookup started in the previous cycle |
| st_en | input | 1 | The lookup in its tag cycle is a store |
| st_be | input | 4 | Byte enables of the store |
| st_data | input | 32 | Store data |
| hit | output | 1 | Address of the lookup in its tag cycle is inside the window |
| rdata | output | 32 | Read word, valid with `hit` |
| no_wthru | output | 1 | Suppress write-through for the current store |
| no_replace | output | 1 | Exclude this way from victim selection |

## Verification
If the registered index or the request flag is wrong, it shows up at once as a wrong `hit` or `rdata` in the tag cycle of the same lookup. A store that lands on a wrong word or on wrong lanes stays hidden until that word is read again. For this reason the stimulus reads words back after partial stores and after aliased misses. A fault in the forwarding path only shows on a load that follows a store to the same word in the very next cycle, so that case is driven on purpose, both with full byte enables and with partial ones.

// File: rtl/spram_way.sv
module spram_way #(
  parameter int PA_W = 32,
  parameter int IDX_W = 20,
  parameter logic [31:0] BASE = 32'h0004_3000,
  parameter int SIZE_BYTES = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_en,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic [PA_W-IDX_W-1:0] tag,
  input  logic                  st_en,
  input  logic [3:0]            st_be,
  input  logic [31:0]           st_data,
  output logic                  hit,
  output logic [31:0]           rdata,
  output logic                  no_wthru,
  output logic                  no_replace
);
  localparam int DEPTH = SIZE_BYTES / 4;
  localparam int AW = $clog2(DEPTH);

  logic [31:0] mem [DEPTH];
  logic [31:0] ram_q;
  logic [31:0] fwd_d_q;
  logic [3:0]  fwd_be_q;
  logic        fwd_q;
  logic        req_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0] merged;

  wire [PA_W:0] pa    = {1'b0, tag, idx_q};
  wire [PA_W:0] lo    = (PA_W+1)'(BASE);
  wire [PA_W:0] hi    = (PA_W+1)'(BASE) + (PA_W+1)'(SIZE_BYTES);
  wire          in_win = (pa >= lo) && (pa < hi);
  wire          we     = st_en && hit;
  wire [AW-1:0] waddr  = idx_q[AW+1:2];
  wire [AW-1:0] raddr  = acc_idx[AW+1:2];

  assign hit        = req_q && in_win;
  assign no_wthru   = we;
  assign no_replace = 1'b1;
  assign rdata      = hit ? merged : 32'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      fwd_q <= 1'b0;
    end else begin
      req_q <= acc_en;
      fwd_q <= acc_en && we && (raddr == waddr);
    end
    idx_q    <= acc_idx;
    fwd_be_q <= st_be;
    fwd_d_q  <= st_data;
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (we && st_be[b]) mem[waddr][8*b +: 8] <= st_data[8*b +: 8];
    if (acc_en) ram_q <= mem[raddr];
  end

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign merged[8*g +: 8] = (fwd_q && fwd_be_q[g]) ? fwd_d_q[8*g +: 8] : ram_q[8*g +: 8];
  end
endmodule

module spram_way_chk #(
  parameter int PA_W = 32,
  parameter int IDX_W = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_en,
  input logic [IDX_W-1:0]      acc_idx,
  input logic                  st_en,
  input logic [3:0]            st_be,
  input logic [31:0]           st_data,
  input logic                  hit,
  input logic [31:0]           rdata,
  input logic                  no_wthru
);
  // R1
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> $past(acc_en));
  // R6
  wthru_only_on_store_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_wthru |-> (hit && st_en));
  // R9
  miss_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (rdata == 32'h0));
  // R5
  store_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_wthru && acc_en && (st_be == 4'hF) &&
     (acc_idx[IDX_W-1:2] == $past(acc_idx[IDX_W-1:2])))
    |=> (!hit || (rdata == $past(st_data))));
endmodule

bind spram_way spram_way_chk #(.PA_W(PA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_idx(acc_idx),
  .st_en(st_en), .st_be(st_be), .st_data(st_data),
  .hit(hit), .rdata(rdata), .no_wthru(no_wthru)
);

// File: tb/sim_spram_way.sv
module sim_spram_way;
  localparam int PERIOD = 10;
  localparam int PA_W = 32;
  localparam int IDX_W = 20;
  localparam logic [31:0] BASE = 32'h0004_3000;
  localparam int SIZE_BYTES = 4096;
  localparam int DEPTH = SIZE_BYTES / 4;
  localparam int TW = PA_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0;
  logic [IDX_W-1:0] acc_idx = '0;
  logic [TW-1:0] tag = '0;
  logic st_en = 1'b0;
  logic [3:0] st_be = '0;
  logic [31:0] st_data = '0;
  logic hit, no_wthru, no_replace;
  logic [31:0] rdata;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [DEPTH];
  bit known [DEPTH];
  bit pend = 1'b0;
  logic [31:0] pend_pa = '0;
  string data_tag = "R2";

  always #(PERIOD/2) clk = ~clk;

  spram_way #(.PA_W(PA_W), .IDX_W(IDX_W), .BASE(BASE), .SIZE_BYTES(SIZE_BYTES)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_idx(acc_idx), .tag(tag),
    .st_en(st_en), .st_be(st_be), .st_data(st_data), .hit(hit), .rdata(rdata),
    .no_wthru(no_wthru), .no_replace(no_replace));

  function automatic bit in_win(input logic [31:0] pa);
    return ({1'b0, pa} >= {1'b0, BASE}) && ({1'b0, pa} < {1'b0, BASE} + 33'(SIZE_BYTES));
  endfunction

  function automatic int widx(input logic [31:0] pa);
    return int'((pa - BASE) >> 2);
  endfunction

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input bit a_en, input logic [31:0] a_pa, input bit s_en,
                      input logic [3:0] be, input logic [31:0] d);
    bit eh;
    int wi;
    @(negedge clk);
    acc_en = a_en;
    acc_idx = a_pa[IDX_W-1:0];
    tag = pend_pa[PA_W-1:IDX_W];
    st_en = s_en;
    st_be = be;
    st_data = d;
    #1;
    eh = pend && in_win(pend_pa);
    wi = eh ? widx(pend_pa) : 0;
    check(hit == eh, "R1", 32'(hit), 32'(eh));
    if (!eh) check(rdata == 32'h0, "R9", rdata, 32'h0);
    else if (known[wi]) check(rdata == model[wi], data_tag, rdata, model[wi]);
    check(no_wthru == (s_en && eh), "R6", 32'(no_wthru), 32'(s_en && eh));
    check(no_replace == 1'b1, "R7", 32'(no_replace), 32'h1);
    if (s_en && eh) begin
      for (int b = 0; b < 4; b++)
        if (be[b]) model[wi][8*b +: 8] = d[8*b +: 8];
      if (be == 4'hF) known[wi] = 1'b1;
    end
    pend = a_en;
    pend_pa = a_pa;
  endtask

  function automatic logic [31:0] rand_pa();
    int r;
    r = int'($urandom % 10);
    if (r < 6) return BASE + (($urandom % SIZE_BYTES) & ~32'h3);
    if (r == 6) return {TW'($urandom), BASE[IDX_W-1:12], 12'(($urandom % SIZE_BYTES) & ~32'h3)};
    if (r == 7) return (($urandom % 2) == 0 ? BASE : BASE + SIZE_BYTES) + 32'(($urandom % 3) * 4) - 32'd4;
    return $urandom & ~32'h3;
  endfunction

  initial begin
    logic [31:0] w0, alias_pa, old;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    #1;
    // R8
    check(hit == 1'b0, "R8", 32'(hit), 32'h0);
    check(rdata == 32'h0, "R8", rdata, 32'h0);
    check(no_wthru == 1'b0, "R8", 32'(no_wthru), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(hit == 1'b0, "R8", 32'(hit), 32'h0);

    // fill every word (R2 base state)
    for (int i = 0; i < DEPTH; i++)
      step(1'b1, BASE + 32'(i * 4), pend, 4'hF, pend ? $urandom : 32'h0);
    step(1'b1, BASE, 1'b1, 4'hF, $urandom);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);

    // R1 boundaries
    step(1'b1, BASE - 32'd4, 1'b0, 4'h0, 32'h0);
    step(1'b1, BASE + SIZE_BYTES - 32'd4, 1'b0, 4'h0, 32'h0);
    step(1'b1, BASE + SIZE_BYTES, 1'b0, 4'h0, 32'h0);
    step(1'b1, BASE, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);

    // R3 partial store then read back later
    w0 = BASE + 32'h40;
    data_tag = "R3";
    step(1'b1, w0, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b1, 4'b0101, 32'hA1B2_C3D4);
    step(1'b1, w0, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);

    // R4 aliased store misses, word keeps value
    data_tag = "R4";
    alias_pa = {TW'(BASE[PA_W-1:IDX_W] + 1), w0[IDX_W-1:0]};
    old = model[widx(w0)];
    step(1'b1, alias_pa, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b1, 4'hF, ~old);
    step(1'b1, w0, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);
    check(model[widx(w0)] == old, "R4", model[widx(w0)], old);

    // R5 store followed at once by a load of the same word, full and partial
    data_tag = "R5";
    step(1'b1, w0, 1'b0, 4'h0, 32'h0);
    step(1'b1, w0, 1'b1, 4'hF, 32'h1234_5678);
    step(1'b1, w0, 1'b1, 4'b1000, 32'hEE00_0000);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] p;
      p = ($urandom % 4 == 0 && pend) ? pend_pa : rand_pa();
      data_tag = (p == pend_pa) ? "R5" : "R2";
      step(($urandom % 8) != 0, p, ($urandom % 2) == 0, 4'($urandom), $urandom);
    end
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);
    step(1'b0, 32'h0, 1'b0, 4'h0, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule